// File: doc/BRIEF.md
# Mode-Controlled 16-Bit Timer Counter

This block is a 16-bit up-counter whose behaviour is set by a two-bit mode field in a small control register. The counter can be held stopped and cleared, left free-running, restarted by a qualified edge on an external trigger, or restarted when it reaches the value of compare register 0. A clock-enable input stands in for the prescaled count clock. Every counting step is taken only in a cycle where that enable is high.

Two compare registers and the control register share one simple write port. The trigger passes through a two-flop synchronizer and then an edge detector. A configuration input selects whether the detector reacts to rising edges, falling edges or both. The block drives a timer output that inverts on compare matches and, if selected, on trigger edges. It also keeps an overflow flag that software can both set and clear.

Top module: `mode_timer16`

## Requirements
- R1: After reset, `cnt_o` is 0, `tout_o` is 0 and `ovf_o` is 0, and the mode is stop (control register all zeros).
- R2: While the registered mode is 00 (stop), the counter is forced to 0 regardless of `cnt_en_i`, `tout_o` holds its value, and `ovf_o` is forced to 0 even if software writes 1 to it.
- R3: In mode 01 (free-run), the counter adds one on every clock where `cnt_en_i` is 1 and holds when it is 0; trigger edges do not restart it.
- R4: In mode 10 (trigger restart), a valid trigger edge clears the counter. A level change on `trig_i` set up before clock edge k is seen by the counter at clock edge k+2, so the counter reads 0 after that edge. This clear does not depend on `cnt_en_i`, and it takes priority over counting.
- R5: `edge_sel_i` encodes the valid edge: 00 falling, 01 rising, 10 no edge (reserved), 11 both edges.
- R6: In mode 11 (match restart), on a clock with `cnt_en_i` high where the counter equals compare register 0, the counter goes to 0 instead of incrementing.
- R7: In every counting mode, a change of the counter from 16'hFFFF to 16'h0000 sets `ovf_o`.
- R8: Control bit 3 is the overflow flag. A control write with bit 3 = 1 sets the flag, and with bit 3 = 0 clears it. A hardware overflow in the same cycle as a clearing write leaves the flag set.
- R9: Control bit 2 is toggle-select. With toggle-select 0, `tout_o` inverts on a clock with `cnt_en_i` high where the counter equals compare register 0 or compare register 1.
- R10: With toggle-select 1, `tout_o` also inverts on a valid trigger edge. Several toggle causes in the same cycle produce a single inversion.
- R11: A control write updates toggle-select only when the registered mode is 00. The mode field (bits 1:0) and the overflow bit are taken on every control write.
- R12: Write address 0 is the control register, 1 is compare register 0, 2 is compare register 1, and 3 is ignored. Compare registers may be written in any mode.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cnt_en_i | input | 1 | Count enable (prescaled tick) |
| trig_i | input | 1 | Asynchronous trigger input |
| edge_sel_i | input | 2 | Valid trigger edge select |
| wr_en_i | input | 1 | Register write strobe |
| wr_addr_i | input | 2 | Register write address |
| wr_data_i | input | 16 | Register write data |
| cnt_o | output | 16 | Counter value |
| tout_o | output | 1 | Toggling timer output |
| ovf_o | output | 1 | Overflow flag |

## Verification
The checker watches several behaviours on every cycle. In the stop state it checks the forced-zero counter, the forced-clear flag and the held output. In free-run and match-restart modes it checks the single increment and the hold when the enable is low. It checks the restart on a match with compare register 0, and it checks that the flag is set whenever the counter leaves all-ones while counting. The bench scenarios are needed for the behaviours that depend on history or on software intent. These are the synchronizer latency and the decoding of each edge-select code, the toggle source choice and its write protection while running, the hardware-over-software priority on the flag, and a single inversion when a trigger edge and a match coincide.

// File: rtl/tmr_pkg.sv
package tmr_pkg;
  typedef enum logic [1:0] {
    MODE_STOP  = 2'b00,
    MODE_FREE  = 2'b01,
    MODE_TRIG  = 2'b10,
    MODE_MATCH = 2'b11
  } tmr_mode_e;

  typedef enum logic [1:0] {
    EDGE_FALL = 2'b00,
    EDGE_RISE = 2'b01,
    EDGE_NONE = 2'b10,
    EDGE_BOTH = 2'b11
  } tmr_edge_e;

  localparam int unsigned ADDR_W        = 2;
  localparam int unsigned ADDR_CTRL     = 0;
  localparam int unsigned ADDR_CMP_BASE = 1;
  localparam int unsigned NUM_CMP       = 2;

  localparam int unsigned CTRL_MODE_LSB = 0;
  localparam int unsigned CTRL_TSEL_BIT = 2;
  localparam int unsigned CTRL_OVF_BIT  = 3;
endpackage

// File: rtl/tmr_edge_det.sv
module tmr_edge_det
  import tmr_pkg::*;
#(
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic      clk_i,
  input  logic      rst_ni,
  input  logic      trig_i,
  input  tmr_edge_e edge_sel_i,
  output logic      edge_o
);
  localparam int unsigned LAST = SYNC_STAGES;

  // [SYNC_STAGES-1:0] synchronizer, [LAST] previous sample
  logic [LAST:0] smp_q;
  logic          cur, prev, rise, fall;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) smp_q <= '0;
    else         smp_q <= {smp_q[LAST-1:0], trig_i};
  end

  assign cur  = smp_q[LAST-1];
  assign prev = smp_q[LAST];
  assign rise = cur & ~prev;
  assign fall = ~cur & prev;

  always_comb begin
    unique case (edge_sel_i)
      EDGE_FALL: edge_o = fall;
      EDGE_RISE: edge_o = rise;
      EDGE_BOTH: edge_o = rise | fall;
      default:   edge_o = 1'b0;
    endcase
  end
endmodule

// File: rtl/tmr_regs.sv
module tmr_regs
  import tmr_pkg::*;
#(
  parameter int unsigned CNT_W = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic [ADDR_W-1:0] wr_addr_i,
  input  logic [CNT_W-1:0]  wr_data_i,
  output tmr_mode_e         mode_o,
  output logic              tsel_o,
  output logic              ovf_wr_o,
  output logic              ovf_val_o,
  output logic [CNT_W-1:0]  cmp0_o,
  output logic [CNT_W-1:0]  cmp1_o
);
  tmr_mode_e        mode_q;
  logic             tsel_q;
  logic             ctrl_wr;
  logic [CNT_W-1:0] cmp_q [NUM_CMP];

  assign ctrl_wr = wr_en_i && (wr_addr_i == ADDR_W'(ADDR_CTRL));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mode_q <= MODE_STOP;
      tsel_q <= 1'b0;
    end else if (ctrl_wr) begin
      mode_q <= tmr_mode_e'(wr_data_i[CTRL_MODE_LSB +: 2]);
      // toggle source is frozen while counting
      if (mode_q == MODE_STOP) tsel_q <= wr_data_i[CTRL_TSEL_BIT];
    end
  end

  for (genvar g = 0; g < NUM_CMP; g++) begin : g_cmp
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)
        cmp_q[g] <= '0;
      else if (wr_en_i && (wr_addr_i == ADDR_W'(ADDR_CMP_BASE + g)))
        cmp_q[g] <= wr_data_i;
    end
  end

  assign mode_o    = mode_q;
  assign tsel_o    = tsel_q;
  assign ovf_wr_o  = ctrl_wr;
  assign ovf_val_o = wr_data_i[CTRL_OVF_BIT];
  assign cmp0_o    = cmp_q[0];
  assign cmp1_o    = cmp_q[1];
endmodule

// File: rtl/tmr_core.sv
module tmr_core
  import tmr_pkg::*;
#(
  parameter int unsigned CNT_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  tmr_mode_e        mode_i,
  input  logic             tsel_i,
  input  logic             tick_i,
  input  logic             edge_i,
  input  logic             ovf_wr_i,
  input  logic             ovf_val_i,
  input  logic [CNT_W-1:0] cmp0_i,
  input  logic [CNT_W-1:0] cmp1_i,
  output logic [CNT_W-1:0] cnt_o,
  output logic             tout_o,
  output logic             ovf_o
);
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             tout_q, ovf_q;
  logic             hit0, hit1, wrap, flip, running;

  assign running = (mode_i != MODE_STOP);
  assign hit0    = tick_i && (cnt_q == cmp0_i);
  assign hit1    = tick_i && (cnt_q == cmp1_i);

  always_comb begin
    cnt_d = cnt_q;
    if (!running)
      cnt_d = '0;
    else if (mode_i == MODE_TRIG && edge_i)
      cnt_d = '0;
    else if (tick_i)
      cnt_d = (mode_i == MODE_MATCH && hit0) ? '0 : cnt_q + 1'b1;
  end

  assign wrap = running && (cnt_q == '1) && (cnt_d == '0);
  assign flip = running && (hit0 || hit1 || (tsel_i && edge_i));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q  <= '0;
      tout_q <= 1'b0;
      ovf_q  <= 1'b0;
    end else begin
      cnt_q <= cnt_d;
      if (flip) tout_q <= ~tout_q;
      if (!running)     ovf_q <= 1'b0;
      else if (wrap)    ovf_q <= 1'b1;   // hardware set beats software clear
      else if (ovf_wr_i) ovf_q <= ovf_val_i;
    end
  end

  assign cnt_o  = cnt_q;
  assign tout_o = tout_q;
  assign ovf_o  = ovf_q;
endmodule

// File: rtl/mode_timer16.sv
module mode_timer16
  import tmr_pkg::*;
#(
  parameter int unsigned CNT_W       = 16,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cnt_en_i,
  input  logic              trig_i,
  input  logic [1:0]        edge_sel_i,
  input  logic              wr_en_i,
  input  logic [ADDR_W-1:0] wr_addr_i,
  input  logic [CNT_W-1:0]  wr_data_i,
  output logic [CNT_W-1:0]  cnt_o,
  output logic              tout_o,
  output logic              ovf_o
);
  tmr_mode_e        mode_w;
  logic             tsel_w, ovf_wr_w, ovf_val_w, edge_w;
  logic [CNT_W-1:0] cmp0_w, cmp1_w;

  tmr_edge_det #(.SYNC_STAGES(SYNC_STAGES)) u_edge (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .trig_i     (trig_i),
    .edge_sel_i (tmr_edge_e'(edge_sel_i)),
    .edge_o     (edge_w)
  );

  tmr_regs #(.CNT_W(CNT_W)) u_regs (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .wr_en_i   (wr_en_i),
    .wr_addr_i (wr_addr_i),
    .wr_data_i (wr_data_i),
    .mode_o    (mode_w),
    .tsel_o    (tsel_w),
    .ovf_wr_o  (ovf_wr_w),
    .ovf_val_o (ovf_val_w),
    .cmp0_o    (cmp0_w),
    .cmp1_o    (cmp1_w)
  );

  tmr_core #(.CNT_W(CNT_W)) u_core (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .mode_i    (mode_w),
    .tsel_i    (tsel_w),
    .tick_i    (cnt_en_i),
    .edge_i    (edge_w),
    .ovf_wr_i  (ovf_wr_w),
    .ovf_val_i (ovf_val_w),
    .cmp0_i    (cmp0_w),
    .cmp1_i    (cmp1_w),
    .cnt_o     (cnt_o),
    .tout_o    (tout_o),
    .ovf_o     (ovf_o)
  );
endmodule

// File: rtl/tmr_chk.sv
module tmr_chk
  import tmr_pkg::*;
#(
  parameter int unsigned CNT_W = 16
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             cnt_en_i,
  input logic [1:0]       mode_i,
  input logic [CNT_W-1:0] cmp0_i,
  input logic [CNT_W-1:0] cnt_o,
  input logic             tout_o,
  input logic             ovf_o
);
  localparam logic [CNT_W-1:0] ALL_ONES = '1;

  // R2
  stop_clears_cnt_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_i == MODE_STOP) |=> (cnt_o == '0));

  // R2
  stop_clears_ovf_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_i == MODE_STOP) |=> !ovf_o);

  // R2
  stop_holds_tout_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_i == MODE_STOP) |=> $stable(tout_o));

  // R3
  free_inc_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_i == MODE_FREE && cnt_en_i && cnt_o != ALL_ONES)
      |=> (cnt_o == $past(cnt_o) + 1'b1));

  // R3
  no_tick_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((mode_i == MODE_FREE || mode_i == MODE_MATCH) && !cnt_en_i) |=> $stable(cnt_o));

  // R6
  match_restart_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_i == MODE_MATCH && cnt_en_i && cnt_o == cmp0_i) |=> (cnt_o == '0));

  // R7
  wrap_sets_ovf_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_i != MODE_STOP && cnt_en_i && cnt_o == ALL_ONES) |=> ovf_o);
endmodule

bind mode_timer16 tmr_chk #(.CNT_W(CNT_W)) u_chk (
  .clk_i    (clk_i),
  .rst_ni   (rst_ni),
  .cnt_en_i (cnt_en_i),
  .mode_i   (mode_w),
  .cmp0_i   (cmp0_w),
  .cnt_o    (cnt_o),
  .tout_o   (tout_o),
  .ovf_o    (ovf_o)
);

// File: tb/sim_mode_timer16.sv
module sim_mode_timer16;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        cnt_en_i = 1'b0;
  logic        trig_i = 1'b0;
  logic [1:0]  edge_sel_i = 2'b01;
  logic        wr_en_i = 1'b0;
  logic [1:0]  wr_addr_i = '0;
  logic [15:0] wr_data_i = '0;
  logic [15:0] cnt_o;
  logic        tout_o, ovf_o;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;
  logic exp_tout = 1'b0;

  always #2 clk_i = ~clk_i;

  mode_timer16 u0 (
    .clk_i(clk_i), .rst_ni(rst_ni), .cnt_en_i(cnt_en_i), .trig_i(trig_i),
    .edge_sel_i(edge_sel_i), .wr_en_i(wr_en_i), .wr_addr_i(wr_addr_i),
    .wr_data_i(wr_data_i), .cnt_o(cnt_o), .tout_o(tout_o), .ovf_o(ovf_o)
  );

  task automatic chk(string req, logic [31:0] got, logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s got=%0h exp=%0h at %0t", req, got, exp, $time);
    end
  endtask

  task automatic step(int n);
    repeat (n) @(negedge clk_i);
  endtask

  task automatic wr(logic [1:0] a, logic [15:0] d);
    wr_en_i = 1'b1; wr_addr_i = a; wr_data_i = d;
    @(negedge clk_i);
    wr_en_i = 1'b0;
  endtask

  function automatic logic [15:0] ctrl(logic ovf, logic tsel, logic [1:0] mode);
    return {12'h000, ovf, tsel, mode};
  endfunction

  task automatic stop_block();
    wr(2'd0, ctrl(1'b0, 1'b0, 2'b00));
    step(4);
    chk("R2 stop cnt", cnt_o, 0);
    chk("R2 stop ovf", ovf_o, 0);
    chk("R2 stop tout hold", tout_o, exp_tout);
  endtask

  task automatic t_reset();
    chk("R1 cnt", cnt_o, 0);
    chk("R1 tout", tout_o, 0);
    chk("R1 ovf", ovf_o, 0);
    cnt_en_i = 1'b1;
    step(3);
    chk("R2 no count in stop", cnt_o, 0);
  endtask

  task automatic t_free();
    trig_i = 1'b0; edge_sel_i = 2'b01;
    stop_block();
    wr(2'd1, 16'd5);
    wr(2'd2, 16'd9);
    wr(2'd0, ctrl(1'b0, 1'b0, 2'b01));
    chk("R3 start at 0", cnt_o, 0);
    step(5);
    chk("R3 count", cnt_o, 5);
    chk("R9 before match", tout_o, exp_tout);
    step(1); exp_tout = ~exp_tout;
    chk("R9 cmp0 toggle", tout_o, exp_tout);
    step(4); exp_tout = ~exp_tout;
    chk("R12 cmp1 addr", cnt_o, 10);
    chk("R9 cmp1 toggle", tout_o, exp_tout);
    trig_i = 1'b1;
    step(3);
    chk("R3 trig no restart", cnt_o, 13);
    chk("R9 trig no toggle", tout_o, exp_tout);
    cnt_en_i = 1'b0;
    step(3);
    chk("R3 hold no enable", cnt_o, 13);
    cnt_en_i = 1'b1;
  endtask

  task automatic t_trig();
    trig_i = 1'b0; edge_sel_i = 2'b01;
    stop_block();
    wr(2'd0, ctrl(1'b0, 1'b1, 2'b10));
    step(2);
    chk("R4 counting", cnt_o, 2);
    trig_i = 1'b1;
    step(2);
    chk("R4 latency", cnt_o, 4);
    step(1); exp_tout = ~exp_tout;
    chk("R4 restart", cnt_o, 0);
    chk("R10 edge toggle", tout_o, exp_tout);
    step(6); exp_tout = ~exp_tout;
    chk("R9 match in trig mode", tout_o, exp_tout);
    trig_i = 1'b0;
    step(3);
    chk("R5 rising ignores fall", cnt_o, 9);
    step(1); exp_tout = ~exp_tout;
    chk("R9 cmp1 toggle", tout_o, exp_tout);
    edge_sel_i = 2'b11; trig_i = 1'b1;
    step(3); exp_tout = ~exp_tout;
    chk("R5 both rise", cnt_o, 0);
    chk("R10 both rise toggle", tout_o, exp_tout);
    trig_i = 1'b0;
    step(3); exp_tout = ~exp_tout;
    chk("R5 both fall", cnt_o, 0);
    chk("R10 both fall toggle", tout_o, exp_tout);
    edge_sel_i = 2'b10; trig_i = 1'b1;
    step(3);
    chk("R5 reserved none", cnt_o, 3);
    chk("R5 reserved no toggle", tout_o, exp_tout);
    edge_sel_i = 2'b00; trig_i = 1'b0;
    step(3); exp_tout = ~exp_tout;
    chk("R5 falling", cnt_o, 0);
    chk("R10 single inversion", tout_o, exp_tout);
  endtask

  task automatic t_ignore();
    wr(2'd0, ctrl(1'b0, 1'b0, 2'b10));
    edge_sel_i = 2'b01; trig_i = 1'b1;
    step(3); exp_tout = ~exp_tout;
    chk("R11 tsel kept", tout_o, exp_tout);
    chk("R11 mode kept", cnt_o, 0);
  endtask

  task automatic t_match();
    stop_block();
    wr(2'd0, ctrl(1'b0, 1'b0, 2'b11));
    step(5);
    chk("R6 reach cmp0", cnt_o, 5);
    step(1); exp_tout = ~exp_tout;
    chk("R6 restart", cnt_o, 0);
    chk("R9 toggle on restart", tout_o, exp_tout);
    step(3);
    cnt_en_i = 1'b0;
    step(4);
    chk("R3 hold in match mode", cnt_o, 3);
    cnt_en_i = 1'b1;
    step(3); exp_tout = ~exp_tout;
    chk("R6 restart again", cnt_o, 0);
    chk("R10 tsel0 trig held", tout_o, exp_tout);
  endtask

  task automatic t_ovf();
    stop_block();
    wr(2'd0, ctrl(1'b0, 1'b0, 2'b01));
    step(65535);
    chk("R7 at top", cnt_o, 16'hFFFF);
    chk("R7 not yet", ovf_o, 0);
    wr(2'd0, ctrl(1'b0, 1'b0, 2'b01));
    chk("R7 wrapped", cnt_o, 0);
    chk("R8 hw beats sw clear", ovf_o, 1);
    wr(2'd0, ctrl(1'b0, 1'b0, 2'b01));
    chk("R8 sw clear", ovf_o, 0);
    wr(2'd0, ctrl(1'b1, 1'b0, 2'b01));
    chk("R8 sw set", ovf_o, 1);
    stop_block();
    wr(2'd0, ctrl(1'b1, 1'b0, 2'b00));
    step(1);
    chk("R2 sw set ignored in stop", ovf_o, 0);
  endtask

  task automatic report();
    if (!done) begin
      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  endtask

  initial begin
    step(3);
    rst_ni = 1'b1;
    step(1);
    t_reset();
    t_free();
    t_trig();
    t_ignore();
    t_match();
    t_ovf();
    report();
  end

  initial begin
    repeat (150000) @(posedge clk_i);
    checks++; fails++;
    $display("FAIL watchdog expired");
    report();
  end
endmodule